// File: doc/BRIEF.md
# Virtual CPU Interrupt Acknowledge Interface

This block gives each virtual CPU a guest-visible interrupt interface. A hypervisor fills a small bank of list entries per CPU, and each entry describes one virtual interrupt. The guest reads an acknowledge register to take the most urgent pending entry, which then becomes active. It writes a completion register to retire the entry that carries a given ID pair. The guest also sees a control register, whose bit 0 enables the interface, and a priority-mask register. A per-CPU virtual IRQ line tells each guest that it has work waiting.

Guest accesses arrive on one 32-bit register port that carries a CPU index and a two-bit register select. The selects are 0 control, 1 priority mask, 2 acknowledge (read) and 3 completion (write). Read data comes back one cycle after the request. The hypervisor loads whole entries through a separate write port. Every entry is visible at all times on a flat output bus, 32 bits per entry, ordered by CPU and then by entry index.

List entry layout: bit 31 hardware-linked, bit 30 group, [29:28] state (0 invalid, 1 pending, 2 active, 3 pending and active), [27:23] priority, bit 19 completion-notify, [12:10] source CPU, [9:0] virtual ID.

Top module: `vai_top`

## Requirements
- R1: An acknowledge read returns 1023 and changes no entry when no entry of that CPU is pending (state 1 or 3) or when its enable bit (control bit 0) is clear.
- R2: Otherwise the acknowledge read returns the chosen entry's virtual ID in [9:0] and its source CPU in [12:10], zeros above, and sets that entry's state to 2 (active) while keeping every other field.
- R3: The chosen entry is the pending entry with the numerically lowest priority field; between equal priorities the lowest entry index wins.
- R4: A completion write (select 3) takes a virtual ID from data [9:0] and a source CPU from [12:10]. It sets to state 0 the lowest-index entry whose state is not 0 and whose ID pair matches, and leaves every other field of that entry as it was.
- R5: A completion write that matches no entry changes no entry.
- R6: The virtual IRQ of a CPU rises one cycle after that CPU has a pending entry with the enable bit set. Once raised, it stays high while any entry is pending, even if the enable bit is cleared. It falls one cycle after no entry is pending.
- R7: Writes to the control register (bit 0) and to the priority-mask register (bits [4:0]) are stored and read back zero-extended.
- R8: An acknowledge that selects an entry with bit 31 set returns 1023, leaves the entry unchanged and pulses that CPU's error output for one cycle, aligned with the read data.
- R9: A hypervisor load replaces a whole entry. If it hits the entry that a guest acknowledge selects in the same cycle, the load wins and the acknowledge returns the ID that was selected before the edge.
- R10: Each CPU's bank is independent: guest accesses to one CPU never change another CPU's entries, enable bit or IRQ.
- R11: After reset every entry, enable bit and priority mask is zero, and every virtual IRQ and error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Guest register access this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_cpu | input | CPU_IW | Target virtual CPU |
| acc_reg | input | 2 | Register select: 0 control, 1 mask, 2 acknowledge, 3 completion |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| hv_we | input | 1 | Hypervisor entry load |
| hv_cpu | input | CPU_IW | CPU of the loaded entry |
| hv_idx | input | LR_IW | Entry index |
| hv_wdata | input | 32 | Entry value |
| lr_state_o | output | NUM_CPU*NUM_LR*32 | All entries, CPU-major |
| virq_o | output | NUM_CPU | Virtual IRQ per CPU |
| hw_err_o | output | NUM_CPU | Acknowledge of a hardware-linked entry |

## Verification
A hypervisor entry load and a guest acknowledge can land on the same CPU and the same entry in one cycle. The bench drives both in a single cycle. The read data must carry the ID chosen before the edge, and the entry must hold the hypervisor's new value, still pending. A following acknowledge must then return the new ID, which shows that the load was not lost under the state update.

// File: rtl/vai_pkg.sv
package vai_pkg;
   localparam int WORD_W     = 32;
   localparam int TAG_W      = 13;
   localparam int PRI_LSB    = 23;
   localparam int PRI_W      = 5;
   localparam int ST_LSB     = 28;
   localparam int HWL_BIT    = 31;
   localparam logic [9:0] NO_IRQ_ID = 10'd1023;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_ACT  = 2'd2,
      ST_PACT = 2'd3
   } lr_st_e;

   typedef enum logic [1:0] {
      REG_CTRL  = 2'd0,
      REG_PMASK = 2'd1,
      REG_ACK   = 2'd2,
      REG_EOI   = 2'd3
   } greg_e;

   function automatic logic [1:0] lr_state(input logic [WORD_W-1:0] w);
      return w[ST_LSB +: 2];
   endfunction

   function automatic logic lr_pending(input logic [WORD_W-1:0] w);
      return w[ST_LSB];
   endfunction

   function automatic logic [PRI_W-1:0] lr_pri(input logic [WORD_W-1:0] w);
      return w[PRI_LSB +: PRI_W];
   endfunction

   function automatic logic [TAG_W-1:0] lr_tag(input logic [WORD_W-1:0] w);
      return w[TAG_W-1:0];
   endfunction

   function automatic logic [WORD_W-1:0] lr_set_state(input logic [WORD_W-1:0] w,
                                                      input lr_st_e st);
      logic [WORD_W-1:0] r;
      r = w;
      r[ST_LSB +: 2] = st;
      return r;
   endfunction
endpackage

// File: rtl/vai_pick.sv
module vai_pick
   import vai_pkg::*;
#(
   parameter int NUM_LR = 4,
   parameter int LR_IW  = 2
) (
   input  logic [NUM_LR-1:0][WORD_W-1:0] lrs,
   output logic                          found,
   output logic [LR_IW-1:0]              idx
);
   logic [PRI_W-1:0] best;

   // strict compare keeps the lowest index among equal priorities
   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '1;
      for (int i = 0; i < NUM_LR; i++) begin
         if (lr_pending(lrs[i]) && (!found || lr_pri(lrs[i]) < best)) begin
            found = 1'b1;
            idx   = LR_IW'(i);
            best  = lr_pri(lrs[i]);
         end
      end
   end
endmodule

// File: rtl/vai_eoi_match.sv
module vai_eoi_match
   import vai_pkg::*;
#(
   parameter int NUM_LR = 4,
   parameter int LR_IW  = 2
) (
   input  logic [NUM_LR-1:0][WORD_W-1:0] lrs,
   input  logic [TAG_W-1:0]              tag,
   output logic                          hit,
   output logic [LR_IW-1:0]              idx
);
   logic [NUM_LR-1:0] cand;

   for (genvar i = 0; i < NUM_LR; i++) begin : g_cand
      assign cand[i] = (lr_state(lrs[i]) != ST_IDLE) && (lr_tag(lrs[i]) == tag);
   end

   always_comb begin
      idx = '0;
      for (int i = NUM_LR - 1; i >= 0; i--) begin
         if (cand[i]) idx = LR_IW'(i);
      end
   end

   assign hit = |cand;
endmodule

// File: rtl/vai_cpu_bank.sv
module vai_cpu_bank
   import vai_pkg::*;
#(
   parameter int NUM_LR  = 4,
   parameter int LR_IW   = 2,
   parameter int PMASK_W = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          acc_sel,
   input  logic                          acc_write,
   input  logic [1:0]                    acc_reg,
   input  logic [WORD_W-1:0]             acc_wdata,
   input  logic                          hv_sel,
   input  logic [LR_IW-1:0]              hv_idx,
   input  logic [WORD_W-1:0]             hv_wdata,
   output logic [WORD_W-1:0]             rdata,
   output logic [NUM_LR-1:0][WORD_W-1:0] lrs_o,
   output logic                          virq_o,
   output logic                          hw_err_o
);
   logic [WORD_W-1:0]  lr_q [NUM_LR];
   logic               en_q;
   logic [PMASK_W-1:0] pmask_q;
   logic               virq_q;
   logic               err_q;

   logic               pick_found;
   logic [LR_IW-1:0]   pick_idx;
   logic               eoi_hit_raw;
   logic [LR_IW-1:0]   eoi_idx;
   logic [NUM_LR-1:0]  pend_vec;
   logic               any_pend;
   logic               ack_rd, ack_take, hw_hit, eoi_wr, eoi_hit;
   logic [WORD_W-1:0]  pick_word;

   for (genvar i = 0; i < NUM_LR; i++) begin : g_pack
      assign lrs_o[i]    = lr_q[i];
      assign pend_vec[i] = lr_pending(lr_q[i]);
   end
   assign any_pend = |pend_vec;

   vai_pick #(.NUM_LR(NUM_LR), .LR_IW(LR_IW)) u_pick (
      .lrs   (lrs_o),
      .found (pick_found),
      .idx   (pick_idx)
   );

   vai_eoi_match #(.NUM_LR(NUM_LR), .LR_IW(LR_IW)) u_match (
      .lrs (lrs_o),
      .tag (acc_wdata[TAG_W-1:0]),
      .hit (eoi_hit_raw),
      .idx (eoi_idx)
   );

   assign pick_word = lrs_o[pick_idx];
   assign ack_rd    = acc_sel && !acc_write && (acc_reg == REG_ACK);
   assign ack_take  = ack_rd && en_q && pick_found && !pick_word[HWL_BIT];
   assign hw_hit    = ack_rd && en_q && pick_found &&  pick_word[HWL_BIT];
   assign eoi_wr    = acc_sel && acc_write && (acc_reg == REG_EOI);
   assign eoi_hit   = eoi_wr && eoi_hit_raw;

   always_comb begin
      unique case (acc_reg)
         REG_CTRL:  rdata = {{(WORD_W-1){1'b0}}, en_q};
         REG_PMASK: rdata = {{(WORD_W-PMASK_W){1'b0}}, pmask_q};
         REG_ACK:   rdata = ack_take ? {{(WORD_W-TAG_W){1'b0}}, lr_tag(pick_word)}
                                     : {{(WORD_W-10){1'b0}}, NO_IRQ_ID};
         default:   rdata = '0;
      endcase
   end

   // entry update: hypervisor load outranks the guest's state change
   for (genvar i = 0; i < NUM_LR; i++) begin : g_lr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lr_q[i] <= '0;
         end else if (hv_sel && hv_idx == LR_IW'(i)) begin
            lr_q[i] <= hv_wdata;
         end else if (ack_take && pick_idx == LR_IW'(i)) begin
            lr_q[i] <= lr_set_state(lr_q[i], ST_ACT);
         end else if (eoi_hit && eoi_idx == LR_IW'(i)) begin
            lr_q[i] <= lr_set_state(lr_q[i], ST_IDLE);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         pmask_q <= '0;
         virq_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (acc_sel && acc_write && acc_reg == REG_CTRL)  en_q    <= acc_wdata[0];
         if (acc_sel && acc_write && acc_reg == REG_PMASK) pmask_q <= acc_wdata[PMASK_W-1:0];
         virq_q <= virq_q ? any_pend : (any_pend && en_q);
         err_q  <= hw_hit;
      end
   end

   assign virq_o   = virq_q;
   assign hw_err_o = err_q;

   AST_ACK_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !ack_take && !hv_sel) |=> $stable(lrs_o)); // R1
   AST_ACK_GOES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && !(hv_sel && hv_idx == pick_idx))
      |=> lr_state(lrs_o[$past(pick_idx)]) == ST_ACT); // R2
   AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_hit && !(hv_sel && hv_idx == eoi_idx))
      |=> lr_state(lrs_o[$past(eoi_idx)]) == ST_IDLE); // R4
   AST_EOI_MISS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !eoi_hit_raw && !hv_sel) |=> $stable(lrs_o)); // R5
   AST_VIRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      virq_o |-> $past(any_pend)); // R6
   AST_HW_ACK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_hit && !hv_sel) |=> ($stable(lrs_o) && hw_err_o)); // R8
endmodule

// File: rtl/vai_top.sv
module vai_top
   import vai_pkg::*;
#(
   parameter int NUM_CPU = 2,
   parameter int NUM_LR  = 4,
   parameter int PMASK_W = 5,
   localparam int CPU_IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
   localparam int LR_IW  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
   localparam int LRS_W  = NUM_CPU * NUM_LR * WORD_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic [CPU_IW-1:0]   acc_cpu,
   input  logic [1:0]          acc_reg,
   input  logic [WORD_W-1:0]   acc_wdata,
   output logic                rsp_valid,
   output logic [WORD_W-1:0]   rsp_rdata,
   input  logic                hv_we,
   input  logic [CPU_IW-1:0]   hv_cpu,
   input  logic [LR_IW-1:0]    hv_idx,
   input  logic [WORD_W-1:0]   hv_wdata,
   output logic [LRS_W-1:0]    lr_state_o,
   output logic [NUM_CPU-1:0]  virq_o,
   output logic [NUM_CPU-1:0]  hw_err_o
);
   if (NUM_CPU < 1 || NUM_CPU > 8) begin : g_bad_cpu
      $error("vai_top: NUM_CPU must lie in 1..8");
   end
   if (NUM_LR < 1 || NUM_LR > 64) begin : g_bad_lr
      $error("vai_top: NUM_LR must lie in 1..64");
   end
   if (PMASK_W < 1 || PMASK_W > 8) begin : g_bad_mask
      $error("vai_top: PMASK_W must lie in 1..8");
   end

   logic [NUM_CPU-1:0]               acc_sel;
   logic [NUM_CPU-1:0]               hv_sel;
   logic [WORD_W-1:0]                bank_rd   [NUM_CPU];
   logic [NUM_LR-1:0][WORD_W-1:0]    bank_lrs  [NUM_CPU];
   logic [WORD_W-1:0]                rd_mux;
   logic                             rsp_v_q;
   logic [WORD_W-1:0]                rsp_d_q;

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
      assign acc_sel[c] = acc_valid && (acc_cpu == CPU_IW'(c));
      assign hv_sel[c]  = hv_we && (hv_cpu == CPU_IW'(c));

      vai_cpu_bank #(.NUM_LR(NUM_LR), .LR_IW(LR_IW), .PMASK_W(PMASK_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .acc_sel   (acc_sel[c]),
         .acc_write (acc_write),
         .acc_reg   (acc_reg),
         .acc_wdata (acc_wdata),
         .hv_sel    (hv_sel[c]),
         .hv_idx    (hv_idx),
         .hv_wdata  (hv_wdata),
         .rdata     (bank_rd[c]),
         .lrs_o     (bank_lrs[c]),
         .virq_o    (virq_o[c]),
         .hw_err_o  (hw_err_o[c])
      );

      for (genvar i = 0; i < NUM_LR; i++) begin : g_flat
         assign lr_state_o[(c*NUM_LR + i)*WORD_W +: WORD_W] = bank_lrs[c][i];
      end

      AST_BANK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
         (!acc_sel[c] && !hv_sel[c]) |=> $stable(bank_lrs[c])); // R10
   end

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CPU; c++) begin
         if (acc_cpu == CPU_IW'(c)) rd_mux = bank_rd[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else begin
         rsp_v_q <= acc_valid && !acc_write;
         if (acc_valid && !acc_write) rsp_d_q <= rd_mux;
      end
   end

   assign rsp_valid = rsp_v_q;
   assign rsp_rdata = rsp_d_q;

   AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(acc_valid && !acc_write)); // R2
endmodule

// File: tb/vai_top_tb.sv
`timescale 1ns/1ps
module vai_top_tb_top;
   localparam int NUM_CPU = 2;
   localparam int NUM_LR  = 4;
   localparam int CPU_IW  = 1;
   localparam int LR_IW   = 2;
   localparam int LRS_W   = NUM_CPU * NUM_LR * 32;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              acc_valid, acc_write;
   logic [CPU_IW-1:0] acc_cpu;
   logic [1:0]        acc_reg;
   logic [31:0]       acc_wdata;
   logic              rsp_valid;
   logic [31:0]       rsp_rdata;
   logic              hv_we;
   logic [CPU_IW-1:0] hv_cpu;
   logic [LR_IW-1:0]  hv_idx;
   logic [31:0]       hv_wdata;
   logic [LRS_W-1:0]  lr_state_o;
   logic [NUM_CPU-1:0] virq_o, hw_err_o;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   vai_top #(.NUM_CPU(NUM_CPU), .NUM_LR(NUM_LR)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_cpu(acc_cpu),
      .acc_reg(acc_reg), .acc_wdata(acc_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .hv_we(hv_we), .hv_cpu(hv_cpu), .hv_idx(hv_idx), .hv_wdata(hv_wdata),
      .lr_state_o(lr_state_o), .virq_o(virq_o), .hw_err_o(hw_err_o)
   );

   // entry image built from the layout in the brief
   function automatic logic [31:0] lrv(input bit hw, input bit grp, input logic [1:0] st,
                                       input logic [4:0] pri, input bit eoi,
                                       input logic [2:0] src, input logic [9:0] id);
      return {hw, grp, st, pri, 3'b000, eoi, 6'b000000, src, id};
   endfunction

   function automatic logic [31:0] setst(input logic [31:0] w, input logic [1:0] st);
      logic [31:0] r;
      r = w;
      r[29:28] = st;
      return r;
   endfunction

   localparam logic [1:0] OP_HV = 2'd0, OP_GW = 2'd1, OP_GR = 2'd2, OP_CK = 2'd3;
   localparam logic [1:0] S_CTRL = 2'd0, S_MASK = 2'd1, S_ACK = 2'd2, S_EOI = 2'd3;

   function automatic logic [72:0] vec(input logic [3:0] req, input logic [1:0] op,
                                       input bit cpu, input logic [1:0] sel,
                                       input logic [31:0] data, input logic [31:0] exp);
      return {req, op, cpu, sel, data, exp};
   endfunction

   localparam logic [31:0] EA = lrv(0, 0, 2'd1, 5'd10, 0, 3'd2, 10'd33);
   localparam logic [31:0] EB = lrv(0, 0, 2'd1, 5'd4,  1, 3'd1, 10'd77);
   localparam logic [31:0] EC = lrv(0, 0, 2'd1, 5'd4,  0, 3'd3, 10'd5);
   localparam logic [31:0] ED = lrv(0, 1, 2'd3, 5'd31, 0, 3'd0, 10'd9);
   localparam logic [31:0] EE = lrv(0, 0, 2'd1, 5'd0,  0, 3'd0, 10'd1);

   localparam int NV = 36;
   localparam logic [72:0] VT [NV] = '{
      vec(4'd11, OP_GR, 0, S_CTRL, 0, 0),                 // R11 enable clear
      vec(4'd11, OP_GR, 0, S_MASK, 0, 0),                 // R11 mask clear
      vec(4'd1,  OP_GR, 0, S_ACK,  0, 1023),              // R1 nothing pending
      vec(4'd9,  OP_HV, 0, 2'd0,   EA, 0),
      vec(4'd1,  OP_GR, 0, S_ACK,  0, 1023),              // R1 disabled
      vec(4'd1,  OP_CK, 0, 2'd0,   0, EA),                // R1 entry untouched
      vec(4'd7,  OP_GW, 0, S_CTRL, 1, 0),
      vec(4'd7,  OP_GR, 0, S_CTRL, 0, 1),                 // R7
      vec(4'd9,  OP_HV, 0, 2'd1,   EB, 0),
      vec(4'd9,  OP_HV, 0, 2'd2,   EC, 0),
      vec(4'd3,  OP_GR, 0, S_ACK,  0, 77 + (1 << 10)),    // R3 tie to lower index
      vec(4'd2,  OP_CK, 0, 2'd1,   0, setst(EB, 2)),      // R2 active
      vec(4'd3,  OP_GR, 0, S_ACK,  0, 5 + (3 << 10)),     // R3
      vec(4'd2,  OP_GR, 0, S_ACK,  0, 33 + (2 << 10)),    // R2
      vec(4'd1,  OP_GR, 0, S_ACK,  0, 1023),              // R1 all active
      vec(4'd4,  OP_GW, 0, S_EOI,  77 + (1 << 10), 0),
      vec(4'd4,  OP_CK, 0, 2'd1,   0, setst(EB, 0)),      // R4
      vec(4'd5,  OP_GW, 0, S_EOI,  999, 0),
      vec(4'd5,  OP_CK, 0, 2'd0,   0, setst(EA, 2)),      // R5
      vec(4'd5,  OP_CK, 0, 2'd2,   0, setst(EC, 2)),      // R5
      vec(4'd5,  OP_GW, 0, S_EOI,  5 + (2 << 10), 0),
      vec(4'd5,  OP_CK, 0, 2'd2,   0, setst(EC, 2)),      // R5 wrong cpu field
      vec(4'd7,  OP_GW, 0, S_MASK, 32'h15, 0),
      vec(4'd7,  OP_GR, 0, S_MASK, 0, 32'h15),            // R7
      vec(4'd9,  OP_HV, 0, 2'd3,   ED, 0),
      vec(4'd2,  OP_GR, 0, S_ACK,  0, 9),                 // R2 pending+active
      vec(4'd2,  OP_CK, 0, 2'd3,   0, setst(ED, 2)),      // R2
      vec(4'd10, OP_HV, 1, 2'd3,   EE, 0),
      vec(4'd10, OP_GR, 1, S_ACK,  0, 1023),              // R10 cpu1 disabled
      vec(4'd10, OP_GR, 0, S_ACK,  0, 1023),              // R10 cpu0 unaffected
      vec(4'd10, OP_CK, 1, 2'd3,   0, EE),                // R10
      vec(4'd10, OP_GW, 1, S_CTRL, 1, 0),
      vec(4'd10, OP_GR, 1, S_ACK,  0, 1),                 // R10
      vec(4'd10, OP_CK, 1, 2'd3,   0, setst(EE, 2)),      // R10
      vec(4'd4,  OP_GW, 0, S_EOI,  9, 0),
      vec(4'd4,  OP_CK, 0, 2'd3,   0, setst(ED, 0))       // R4
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input bit g, input bit wr, input bit cpu, input logic [1:0] sel,
                        input logic [31:0] d, input bit hv, input bit hcpu,
                        input logic [1:0] hidx, input logic [31:0] hd);
      @(negedge clk);
      acc_valid = g; acc_write = wr; acc_cpu = cpu; acc_reg = sel; acc_wdata = d;
      hv_we = hv; hv_cpu = hcpu; hv_idx = hidx; hv_wdata = hd;
      @(negedge clk);
      acc_valid = 0; acc_write = 0; hv_we = 0;
   endtask

   function automatic logic [31:0] lr_at(input bit cpu, input logic [1:0] idx);
      return lr_state_o[(int'(cpu)*NUM_LR + int'(idx))*32 +: 32];
   endfunction

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [31:0] tmp;
      rst_n = 0; acc_valid = 0; acc_write = 0; acc_cpu = 0; acc_reg = 0; acc_wdata = 0;
      hv_we = 0; hv_cpu = 0; hv_idx = 0; hv_wdata = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      check("R11 virq", {30'd0, virq_o}, 0);
      check("R11 entries", {31'd0, (lr_state_o == '0)}, 1);

      for (int k = 0; k < NV; k++) begin
         logic [72:0] v;
         string rq;
         v  = VT[k];
         rq = $sformatf("R%0d vec%0d", v[72:69], k);
         unique case (v[68:67])
            OP_HV: drive(0, 0, 0, 0, 0, 1, v[66], v[65:64], v[63:32]);
            OP_GW: drive(1, 1, v[66], v[65:64], v[63:32], 0, 0, 0, 0);
            OP_GR: begin
               drive(1, 0, v[66], v[65:64], 0, 0, 0, 0, 0);
               check(rq, rsp_rdata, v[31:0]);
            end
            default: check(rq, lr_at(v[66], v[65:64]), v[31:0]);
         endcase
      end

      // R6 rise: cpu0 enabled, nothing pending yet
      check("R6 idle low", {31'd0, virq_o[0]}, 0);
      drive(0, 0, 0, 0, 0, 1, 0, 2'd1, lrv(0, 0, 2'd1, 5'd2, 0, 3'd0, 10'd50));
      @(negedge clk);
      check("R6 rise", {31'd0, virq_o[0]}, 1);
      // R6 stays high after enable cleared; R1 acknowledge blocked
      drive(1, 1, 0, S_CTRL, 0, 0, 0, 0, 0);
      @(negedge clk);
      check("R6 held", {31'd0, virq_o[0]}, 1);
      drive(1, 0, 0, S_ACK, 0, 0, 0, 0, 0);
      check("R1 disabled ack", rsp_rdata, 1023);
      drive(1, 1, 0, S_CTRL, 1, 0, 0, 0, 0);

      // R8 hardware-linked entry at top priority
      tmp = lrv(1, 0, 2'd1, 5'd0, 0, 3'd0, 10'd60);
      drive(0, 0, 0, 0, 0, 1, 0, 2'd3, tmp);
      drive(1, 0, 0, S_ACK, 0, 0, 0, 0, 0);
      check("R8 data", rsp_rdata, 1023);
      check("R8 err", {31'd0, hw_err_o[0]}, 1);
      check("R8 entry", lr_at(0, 2'd3), tmp);
      @(negedge clk);
      check("R8 pulse", {31'd0, hw_err_o[0]}, 0);
      drive(0, 0, 0, 0, 0, 1, 0, 2'd3, 0);

      // R9 collision: load and acknowledge hit entry 1 together
      tmp = lrv(0, 0, 2'd1, 5'd2, 0, 3'd0, 10'd51);
      drive(1, 0, 0, S_ACK, 0, 1, 0, 2'd1, tmp);
      check("R9 old id", rsp_rdata, 50);
      check("R9 load wins", lr_at(0, 2'd1), tmp);
      drive(1, 0, 0, S_ACK, 0, 0, 0, 0, 0);
      check("R9 new id", rsp_rdata, 51);
      @(negedge clk);
      check("R6 fall", {31'd0, virq_o[0]}, 0);

      // R11 reset in mid run
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      check("R11 entries after reset", {31'd0, (lr_state_o == '0)}, 1);
      check("R11 virq after reset", {30'd0, virq_o}, 0);
      drive(1, 0, 1, S_CTRL, 0, 0, 0, 0, 0);
      check("R11 enable after reset", rsp_rdata, 0);
      finish_run();
   end
endmodule